// File: doc/BRIEF.md
# Rename Table with Result-Bus Writeback

This block holds the register alias table and the architectural register file of an out-of-order core. Each architectural register has one map entry: a busy bit and the tag of the reservation station that will produce its next value. Instructions arrive in program order. For each one, the issue port looks up two source indices. A lookup returns either a value that is ready to use or the tag of the producer the instruction must wait for. The same port then points the destination register at the tag of the station that took the instruction.

Several functional units can finish in the same cycle, but they share one result bus. A fixed-priority arbiter picks one of them. The unit with the longest latency sits at the highest index and always wins. Units that lose see a stall bit and present their result again on the next cycle. The granted (tag, value) pair goes out as the broadcast. Every map entry that holds that tag is freed, and its register takes the value on the same clock edge. A broadcast whose tag no entry holds changes nothing.

Top module: `rename_bcast_table`

## Requirements
- R1: After reset every map entry is free and every register holds zero, so any source lookup reports ready with value 0.
- R2: A source whose entry is free reports ready with the register-file value. A source whose entry is busy, and whose tag is not on the bus this cycle, reports not ready, and its tag output carries the entry's tag.
- R3: With `iss_valid` and `iss_dst_en` high, from the next cycle the entry for `iss_dst` is busy and holds `iss_tag`.
- R4: When the bus is valid, every busy entry whose tag equals the bus tag becomes free on the next cycle, and its register then holds the bus value.
- R5: A bus result whose tag no busy entry holds leaves every entry and every register unchanged.
- R6: If an issue remaps a register in the same cycle that the bus frees that register's entry, the entry ends busy with the issuing tag. The register file still takes the bus value.
- R7: The bus carries the requesting unit with the highest index: `bus_tag` and `bus_value` are that unit's fields. `bus_valid` is high exactly when any unit requests.
- R8: `fu_stall[u]` is high exactly when unit u requests and is not granted.
- R9: A lookup that hits a busy entry whose tag is on the bus in that same cycle reports ready with the bus value.
- R10: Lookups use the table as it stands before the same instruction's remap, so a source equal to the destination sees the older mapping.
- R11: With `iss_valid` low, or `iss_dst_en` low, no entry is remapped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| iss_valid | input | 1 | An instruction issues this cycle |
| iss_dst_en | input | 1 | The issuing instruction writes a destination |
| iss_src_a | input | IW | First source register index |
| iss_src_b | input | IW | Second source register index |
| iss_dst | input | IW | Destination register index |
| iss_tag | input | TW | Tag of the station that received the instruction |
| src_a_ready | output | 1 | First source value is available |
| src_a_value | output | DW | First source value |
| src_a_tag | output | TW | First source producer tag |
| src_b_ready | output | 1 | Second source value is available |
| src_b_value | output | DW | Second source value |
| src_b_tag | output | TW | Second source producer tag |
| fu_req | input | NUNIT | Unit has a finished result |
| fu_tag | input | NUNIT*TW | Result tags, unit u in slice u |
| fu_value | input | NUNIT*DW | Result values, unit u in slice u |
| fu_stall | output | NUNIT | Unit lost arbitration and must hold its result |
| bus_valid | output | 1 | Broadcast bus carries a result |
| bus_tag | output | TW | Broadcast tag |
| bus_value | output | DW | Broadcast value |

## Verification
Lookup results, bus fields and stall bits are combinational, so they are due in the same cycle as the inputs that cause them. The bench compares them a quarter period after it drives its inputs on the falling edge. Remaps, entry releases and register writes take effect at the next rising edge. The bench advances its reference table at that edge and sees those effects only through the following cycle's lookups. Directed cycles cover issue colliding with a release, stale tags, reading a register that is also the destination, and simultaneous requests. Seeded random cycles cover the rest.

// File: rtl/rtab_pkg.sv
package rtab_pkg;
   localparam int unsigned RT_NREG_DEF  = 8;
   localparam int unsigned RT_DW_DEF    = 16;
   localparam int unsigned RT_TW_DEF    = 3;
   localparam int unsigned RT_NUNIT_DEF = 3;
endpackage

// File: rtl/rtab_arb.sv
module rtab_arb #(
   parameter int unsigned NUNIT = rtab_pkg::RT_NUNIT_DEF,
   localparam int unsigned UW   = (NUNIT > 1) ? $clog2(NUNIT) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [NUNIT-1:0] req,
   output logic [NUNIT-1:0] grant,
   output logic [UW-1:0]    sel,
   output logic             any
);
   assign any = |req;

   generate
      if (NUNIT == 1) begin : g_single
         assign grant = req;
         assign sel   = '0;
      end else begin : g_prio
         // highest index = slowest unit, scanned last so it wins
         always_comb begin
            sel = '0;
            for (int u = 0; u < NUNIT; u++)
               if (req[u]) sel = UW'(u);
         end
         always_comb begin
            grant = '0;
            if (any) grant[sel] = 1'b1;
         end
      end
   endgenerate

   // R7
   grant_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(grant) && (any == (grant != '0)));
   // R8
   grant_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (grant & ~req) == '0);
endmodule

// File: rtl/rtab_map.sv
module rtab_map #(
   parameter int unsigned NREG = rtab_pkg::RT_NREG_DEF,
   parameter int unsigned TW   = rtab_pkg::RT_TW_DEF,
   localparam int unsigned IW  = $clog2(NREG)
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     iss_wr,
   input  logic [IW-1:0]            iss_dst,
   input  logic [TW-1:0]            iss_tag,
   input  logic                     bc_valid,
   input  logic [TW-1:0]            bc_tag,
   output logic [NREG-1:0]          busy_q,
   output logic [NREG-1:0][TW-1:0]  tag_q,
   output logic [NREG-1:0]          hit_vec
);
   genvar r;
   generate
      for (r = 0; r < NREG; r++) begin : g_ent
         logic take;
         assign hit_vec[r] = bc_valid && busy_q[r] && (tag_q[r] == bc_tag);
         assign take       = iss_wr && (iss_dst == IW'(r));
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               busy_q[r] <= 1'b0;
               tag_q[r]  <= '0;
            end else if (take) begin
               busy_q[r] <= 1'b1;      // issue applied last: wins
               tag_q[r]  <= iss_tag;
            end else if (hit_vec[r]) begin
               busy_q[r] <= 1'b0;
            end
         end
      end
   endgenerate

   // R3
   issue_remap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      iss_wr |=> busy_q[$past(iss_dst)] && (tag_q[$past(iss_dst)] == $past(iss_tag)));
   // R5
   stale_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bc_valid && (hit_vec == '0) && !iss_wr) |=> $stable(busy_q) && $stable(tag_q));
   // R4
   release_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!iss_wr && (hit_vec != '0)) |=>
         ($countones(busy_q) == $past($countones(busy_q)) - $past($countones(hit_vec))));
endmodule

// File: rtl/rtab_regs.sv
module rtab_regs #(
   parameter int unsigned NREG = rtab_pkg::RT_NREG_DEF,
   parameter int unsigned DW   = rtab_pkg::RT_DW_DEF
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [NREG-1:0]         we,
   input  logic [DW-1:0]           wdata,
   output logic [NREG-1:0][DW-1:0] rdata
);
   genvar r;
   generate
      for (r = 0; r < NREG; r++) begin : g_reg
         always_ff @(posedge clk) begin
            if (!rst_n)     rdata[r] <= '0;
            else if (we[r]) rdata[r] <= wdata;
         end
      end
   endgenerate

   // R5
   no_write_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (we == '0) |=> $stable(rdata));
endmodule

// File: rtl/rename_bcast_table.sv
module rename_bcast_table #(
   parameter int unsigned NREG  = rtab_pkg::RT_NREG_DEF,
   parameter int unsigned DW    = rtab_pkg::RT_DW_DEF,
   parameter int unsigned TW    = rtab_pkg::RT_TW_DEF,
   parameter int unsigned NUNIT = rtab_pkg::RT_NUNIT_DEF,
   localparam int unsigned IW   = $clog2(NREG),
   localparam int unsigned UW   = (NUNIT > 1) ? $clog2(NUNIT) : 1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                iss_valid,
   input  logic                iss_dst_en,
   input  logic [IW-1:0]       iss_src_a,
   input  logic [IW-1:0]       iss_src_b,
   input  logic [IW-1:0]       iss_dst,
   input  logic [TW-1:0]       iss_tag,
   output logic                src_a_ready,
   output logic [DW-1:0]       src_a_value,
   output logic [TW-1:0]       src_a_tag,
   output logic                src_b_ready,
   output logic [DW-1:0]       src_b_value,
   output logic [TW-1:0]       src_b_tag,
   input  logic [NUNIT-1:0]    fu_req,
   input  logic [NUNIT*TW-1:0] fu_tag,
   input  logic [NUNIT*DW-1:0] fu_value,
   output logic [NUNIT-1:0]    fu_stall,
   output logic                bus_valid,
   output logic [TW-1:0]       bus_tag,
   output logic [DW-1:0]       bus_value
);
   initial begin
      assert (NREG >= 2 && (1 << IW) == NREG) else $error("NREG must be a power of two");
      assert (DW >= 1 && TW >= 1) else $error("widths must be positive");
      assert (NUNIT >= 1) else $error("need at least one unit");
   end

   logic [NUNIT-1:0]          grant;
   logic [UW-1:0]             sel;
   logic                      any;
   logic [NREG-1:0]           busy_q, hit_vec;
   logic [NREG-1:0][TW-1:0]   tag_q;
   logic [NREG-1:0][DW-1:0]   rf;
   logic                      iss_wr;

   rtab_arb #(.NUNIT(NUNIT)) u_arb (
      .clk(clk), .rst_n(rst_n), .req(fu_req), .grant(grant), .sel(sel), .any(any));

   assign bus_valid = any;
   assign bus_tag   = fu_tag[sel*TW +: TW];
   assign bus_value = fu_value[sel*DW +: DW];
   assign fu_stall  = fu_req & ~grant;
   assign iss_wr    = iss_valid && iss_dst_en;

   rtab_map #(.NREG(NREG), .TW(TW)) u_map (
      .clk(clk), .rst_n(rst_n), .iss_wr(iss_wr), .iss_dst(iss_dst), .iss_tag(iss_tag),
      .bc_valid(bus_valid), .bc_tag(bus_tag),
      .busy_q(busy_q), .tag_q(tag_q), .hit_vec(hit_vec));

   rtab_regs #(.NREG(NREG), .DW(DW)) u_regs (
      .clk(clk), .rst_n(rst_n), .we(hit_vec), .wdata(bus_value), .rdata(rf));

   // two lookup ports, each reading pre-issue state with bus forwarding
   logic [1:0][IW-1:0] lk_idx;
   logic [1:0]         lk_rdy;
   logic [1:0][DW-1:0] lk_val;
   logic [1:0][TW-1:0] lk_tag;
   assign lk_idx[0] = iss_src_a;
   assign lk_idx[1] = iss_src_b;

   genvar p;
   generate
      for (p = 0; p < 2; p++) begin : g_look
         always_comb begin
            lk_tag[p] = tag_q[lk_idx[p]];
            lk_rdy[p] = !busy_q[lk_idx[p]] || hit_vec[lk_idx[p]];
            lk_val[p] = hit_vec[lk_idx[p]] ? bus_value : rf[lk_idx[p]];
         end
         // R2
         busy_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (busy_q[lk_idx[p]] && !bus_valid) |-> !lk_rdy[p]);
         // R9
         forward_chk: assert property (@(posedge clk) disable iff (!rst_n)
            hit_vec[lk_idx[p]] |-> lk_rdy[p] && (lk_val[p] == bus_value));
      end
   endgenerate

   assign src_a_ready = lk_rdy[0];
   assign src_a_value = lk_val[0];
   assign src_a_tag   = lk_tag[0];
   assign src_b_ready = lk_rdy[1];
   assign src_b_value = lk_val[1];
   assign src_b_tag   = lk_tag[1];

   // R8
   stall_loser_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($countones(fu_req) > 1) |-> ($countones(fu_stall) == $countones(fu_req) - 1));
endmodule

// File: tb/rename_bcast_table_bench.sv
module rename_bcast_table_bench;
   localparam int NREG = 8, DW = 16, TW = 3, NU = 3, IW = 3;
   localparam int CLK_PERIOD = 10;

   logic clk = 0, rst_n = 0;
   logic iss_valid = 0, iss_dst_en = 0;
   logic [IW-1:0] iss_src_a = 0, iss_src_b = 0, iss_dst = 0;
   logic [TW-1:0] iss_tag = 0;
   logic src_a_ready, src_b_ready;
   logic [DW-1:0] src_a_value, src_b_value;
   logic [TW-1:0] src_a_tag, src_b_tag;
   logic [NU-1:0] fu_req = 0, fu_stall;
   logic [NU*TW-1:0] fu_tag = 0;
   logic [NU*DW-1:0] fu_value = 0;
   logic bus_valid;
   logic [TW-1:0] bus_tag;
   logic [DW-1:0] bus_value;

   int vectors = 0, miscompares = 0;
   bit done = 0;

   // reference state
   bit            m_busy [NREG];
   bit [TW-1:0]   m_tag  [NREG];
   bit [DW-1:0]   m_rf   [NREG];

   always #(CLK_PERIOD/2) clk = ~clk;

   rename_bcast_table u_rename_bcast_table (.*);

   function automatic int win_unit();
      int w = -1;
      for (int u = 0; u < NU; u++) if (fu_req[u]) w = u;
      return w;
   endfunction

   task automatic cmp(string req, string what, logic [31:0] act, logic [31:0] exp);
      vectors++;
      if (act !== exp) begin
         miscompares++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic check_src(string lbl, logic [IW-1:0] s, logic rdy, logic [DW-1:0] v, logic [TW-1:0] t);
      int w = win_unit();
      bit [TW-1:0] bt = (w >= 0) ? fu_tag[w*TW +: TW] : '0;
      bit [DW-1:0] bv = (w >= 0) ? fu_value[w*DW +: DW] : '0;
      if (!m_busy[s]) begin
         cmp(lbl, "ready", rdy, 1); cmp(lbl, "value", v, m_rf[s]);
      end else if (w >= 0 && m_tag[s] == bt) begin
         cmp("R9", "fwd ready", rdy, 1); cmp("R9", "fwd value", v, bv);
      end else begin
         cmp(lbl, "ready", rdy, 0); cmp(lbl, "tag", t, m_tag[s]);
      end
   endtask

   // one cycle: inputs already driven after negedge
   task automatic step(string lbl);
      int w;
      bit [TW-1:0] bt; bit [DW-1:0] bv;
      bit hit [NREG];
      #(CLK_PERIOD/4);
      w = win_unit();
      check_src(lbl, iss_src_a, src_a_ready, src_a_value, src_a_tag);
      check_src(lbl, iss_src_b, src_b_ready, src_b_value, src_b_tag);
      cmp("R7", "bus_valid", bus_valid, (w >= 0));
      if (w >= 0) begin
         cmp("R7", "bus_tag", bus_tag, fu_tag[w*TW +: TW]);
         cmp("R7", "bus_value", bus_value, fu_value[w*DW +: DW]);
      end
      for (int u = 0; u < NU; u++)
         cmp("R8", "stall", fu_stall[u], fu_req[u] && (u != w));
      bt = (w >= 0) ? fu_tag[w*TW +: TW] : '0;
      bv = (w >= 0) ? fu_value[w*DW +: DW] : '0;
      @(posedge clk);
      for (int r = 0; r < NREG; r++) hit[r] = (w >= 0) && m_busy[r] && m_tag[r] == bt;
      for (int r = 0; r < NREG; r++) if (hit[r]) begin m_rf[r] = bv; m_busy[r] = 0; end
      if (iss_valid && iss_dst_en) begin m_busy[iss_dst] = 1; m_tag[iss_dst] = iss_tag; end
      @(negedge clk);
   endtask

   task automatic drive(bit v, bit de, int sa, int sb, int d, int t);
      iss_valid = v; iss_dst_en = de;
      iss_src_a = IW'(sa); iss_src_b = IW'(sb); iss_dst = IW'(d); iss_tag = TW'(t);
   endtask

   task automatic unit(int u, bit rq, int t, int v);
      fu_req[u] = rq; fu_tag[u*TW +: TW] = TW'(t); fu_value[u*DW +: DW] = DW'(v);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
         $finish;
      end
   endtask

   initial begin
      #(CLK_PERIOD*40000);
      miscompares++;
      $display("FAIL watchdog expired actual=hung expected=done");
      finish_run();
   end

   initial begin
      int seed = 32'h5eed;
      void'($urandom(seed));
      for (int r = 0; r < NREG; r++) begin m_busy[r] = 0; m_tag[r] = 0; m_rf[r] = 0; end
      repeat (3) @(negedge clk);
      rst_n = 1;
      // R1: every register ready with zero
      for (int r = 0; r < NREG; r++) begin
         drive(0, 0, r, NREG-1-r, 0, 0);
         step("R1");
      end
      // R3: remap r3 to tag 5, then look it up
      drive(1, 1, 0, 0, 3, 5); step("R3");
      drive(0, 0, 3, 3, 0, 0); step("R3");
      // R11: dst_en low, then valid low: r4 untouched
      drive(1, 0, 0, 0, 4, 2); step("R11");
      drive(0, 1, 0, 0, 4, 2); step("R11");
      drive(0, 0, 4, 4, 0, 0); step("R11");
      // R6: issue r3 to tag 6 while unit 0 broadcasts tag 5
      drive(1, 1, 3, 0, 3, 6); unit(0, 1, 5, 16'h1234); step("R10");
      unit(0, 0, 0, 0);
      drive(0, 0, 3, 3, 0, 0); step("R6");
      // R5: stale tag 5 again
      unit(1, 1, 5, 16'hdead); drive(0, 0, 3, 0, 0, 0); step("R5");
      unit(1, 0, 0, 0); drive(0, 0, 3, 1, 0, 0); step("R5");
      // R4 / R9: release tag 6 with forwarding, then read back
      unit(2, 1, 6, 16'hbeef); drive(0, 0, 3, 3, 0, 0); step("R4");
      unit(2, 0, 0, 0); step("R4");
      // R7 / R8: all units at once; slowest wins
      drive(1, 1, 2, 2, 2, 1); step("R2");
      unit(0, 1, 1, 16'h0a0a); unit(1, 1, 1, 16'h0b0b); unit(2, 1, 1, 16'h0c0c);
      drive(0, 0, 2, 2, 0, 0); step("R7");
      unit(2, 0, 0, 0); step("R8");
      unit(0, 0, 0, 0); unit(1, 0, 0, 0); step("R2");
      // random mix
      for (int i = 0; i < 3000; i++) begin
         drive($urandom_range(0, 1), $urandom_range(0, 3) != 0,
               $urandom_range(0, NREG-1), $urandom_range(0, NREG-1),
               $urandom_range(0, NREG-1), $urandom_range(0, (1<<TW)-1));
         for (int u = 0; u < NU; u++)
            unit(u, $urandom_range(0, 2) == 0, $urandom_range(0, (1<<TW)-1), $urandom_range(0, 65535));
         step("R2");
      end
      finish_run();
   end
endmodule